// File: doc/BRIEF.md
# Dual-Lane Saturating Absolute Value Unit

This execution unit takes a 32-bit source word and treats it as two packed signed 16-bit lanes. Each lane is turned into its absolute value on its own. The one lane value whose magnitude has no positive 16-bit encoding, the most negative one, is clipped to the largest positive value. The two lane results are packed back into a 32-bit result in the same lane positions as the source.

Each operation carries a 32-bit predicate word and a destination register index. The least significant bit of the predicate decides whether the result is committed. The unit does not hold the register file. It emits a write enable next to the result, and a false predicate leaves that enable low so that the destination keeps its old contents.

The unit is built as a two-stage pipeline and takes one operation per cycle. The input side and the result side use valid/ready handshakes with a single stall signal for the whole pipe. While `res_valid` is high and `out_ready` is low, the result, its write enable and its index are held, and `in_ready` is driven low. A source that offers an operation must keep its inputs steady until it sees `in_ready`. When `res_valid` is low, `in_ready` is high no matter what `out_ready` does, so an empty output slot never blocks issue.

Top module: `dhw_sat_abs_unit`

## Requirements
- R1: The low lane is source bits 15:0 and the high lane is source bits 31:16. The result for the low lane appears in result bits 15:0 and the result for the high lane in bits 31:16. Neither lane's value affects the other lane's result.
- R2: A lane holding 0x8000 (-32768) produces 0x7fff.
- R3: A negative lane other than 0x8000 produces its two's-complement negation. A lane in 0x0000..0x7fff passes through unchanged. For example, 0xffff0032 gives 0x00010032 and 0x7fffffff gives 0x7fff0001.
- R4: Every lane of every result lies in 0x0000..0x7fff, so result bits 15 and 31 are always 0.
- R5: `res_we` equals bit 0 of the predicate that was issued with the operation, and it is only high while `res_valid` is high. Predicate bits 31:1 have no effect on any output.
- R6: With `out_ready` held high, an operation accepted in cycle c is presented on the result port in cycle c+2.
- R7: One operation can be accepted every cycle. Results leave in the order of issue, one per accepted operation.
- R8: `res_dest` is the destination index issued with the same operation.
- R9: While `res_valid` is high and `out_ready` is low, `res_data`, `res_we`, `res_dest` and `res_valid` keep their values, and `in_ready` is low.
- R10: A synchronous reset discards every operation in flight. In the cycle after reset, `res_valid` is low, and none of the discarded operations ever appears on the result port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit accepts the offered operation this cycle |
| in_operand | input | 32 | Source word holding two signed 16-bit lanes |
| in_guard | input | 32 | Predicate word; only bit 0 is used |
| in_dest | input | 5 | Destination register index |
| out_ready | input | 1 | The consumer takes the presented result |
| res_valid | output | 1 | A result is presented |
| res_we | output | 1 | Commit the result to the destination |
| res_dest | output | 5 | Destination index of the presented result |
| res_data | output | 32 | Packed saturated absolute values |

## Verification
The hardest case to reach from the ports is a stall that arrives while both stages are full and new operations keep being offered. In that case the held result, the blocked input and the operation waiting in the first stage must all come through in order, and nothing may be lost or repeated. The bench reaches it with a long phase in which both the offer and the consumer's ready toggle at random every cycle, while a scoreboard tracks every accepted operation. A reset issued with both stages occupied and the consumer stalled checks that those operations are dropped. The arithmetic is covered by a full sweep of each lane through all 65536 values, with the other lane cycling through the boundary values.

// File: rtl/dhw_pkg.sv
package dhw_pkg;
  // Default geometry of the unit: two 16-bit lanes in a 32-bit word.
  localparam int DHW_LANE_W = 16;
  localparam int DHW_LANES  = 2;
  localparam int DHW_IDX_W  = 5;
endpackage

// File: rtl/dhw_abs_lane.sv
// Saturating absolute value of one signed lane.
module dhw_abs_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (x == MIN_NEG)   y = MAX_POS;
    else if (x[W-1])    y = W'(0) - x;
    else                y = x;
  end
endmodule

// File: rtl/dhw_lane_array.sv
// Splits a packed word into lanes and applies the lane operation to each.
module dhw_lane_array #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2
) (
  input  logic [LANE_W*LANES-1:0] src,
  output logic [LANE_W*LANES-1:0] dst
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dhw_abs_lane #(.W(LANE_W)) u_lane (
      .x (src[g*LANE_W +: LANE_W]),
      .y (dst[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/dhw_pipe_reg.sv
// One pipeline slot: the valid bit is reset, the payload is not.
module dhw_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q_valid <= 1'b0;
    else if (en) q_valid <= d_valid;
  end

  always_ff @(posedge clk) begin
    if (en) q <= d;
  end
endmodule

// File: rtl/dhw_sat_abs_unit.sv
module dhw_sat_abs_unit
  import dhw_pkg::*;
#(
  parameter int LANE_W = DHW_LANE_W,
  parameter int LANES  = DHW_LANES,
  parameter int IDX_W  = DHW_IDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANE_W*LANES-1:0] in_operand,
  input  logic [LANE_W*LANES-1:0] in_guard,
  input  logic [IDX_W-1:0]        in_dest,
  input  logic                    out_ready,
  output logic                    res_valid,
  output logic                    res_we,
  output logic [IDX_W-1:0]        res_dest,
  output logic [LANE_W*LANES-1:0] res_data
);
  localparam int DW  = LANE_W * LANES;
  localparam int S1W = DW + 1 + IDX_W;
  localparam int S2W = DW + 1 + IDX_W;

  logic              adv;
  logic              s1_valid, s2_valid;
  logic [S1W-1:0]    s1_q;
  logic [S2W-1:0]    s2_q;
  logic [DW-1:0]     s1_operand, s1_abs;
  logic              s1_guard, s2_guard;
  logic [IDX_W-1:0]  s1_dest;
  logic              unused_guard_hi;

  // Only the predicate's bit 0 is used.
  assign unused_guard_hi = ^in_guard[DW-1:1];

  // The whole pipe moves unless a held result is blocking the last stage.
  assign adv      = ~s2_valid | out_ready;
  assign in_ready = adv;

  dhw_pipe_reg #(.W(S1W)) u_stage1 (
    .clk     (clk),
    .rst     (rst),
    .en      (adv),
    .d_valid (in_valid),
    .d       ({in_operand, in_guard[0], in_dest}),
    .q_valid (s1_valid),
    .q       (s1_q)
  );

  assign {s1_operand, s1_guard, s1_dest} = s1_q;

  dhw_lane_array #(.LANE_W(LANE_W), .LANES(LANES)) u_lanes (
    .src (s1_operand),
    .dst (s1_abs)
  );

  dhw_pipe_reg #(.W(S2W)) u_stage2 (
    .clk     (clk),
    .rst     (rst),
    .en      (adv),
    .d_valid (s1_valid),
    .d       ({s1_abs, s1_guard, s1_dest}),
    .q_valid (s2_valid),
    .q       (s2_q)
  );

  assign {res_data, s2_guard, res_dest} = s2_q;
  assign res_valid = s2_valid;
  assign res_we    = s2_valid & s2_guard;
endmodule

// File: rtl/dhw_sat_abs_chk.sv
module dhw_sat_abs_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 2,
  parameter int IDX_W  = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [LANE_W*LANES-1:0] in_operand,
  input logic                    guard0,
  input logic [IDX_W-1:0]        in_dest,
  input logic                    out_ready,
  input logic                    res_valid,
  input logic                    res_we,
  input logic [IDX_W-1:0]        res_dest,
  input logic [LANE_W*LANES-1:0] res_data
);
  localparam int DW = LANE_W * LANES;
  localparam logic [LANE_W-1:0] MIN_NEG = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] MAX_POS = {1'b0, {(LANE_W-1){1'b1}}};

  logic [DW-1:0] sign_mask;
  always_comb begin
    sign_mask = '0;
    for (int i = 0; i < LANES; i++) sign_mask[i*LANE_W + LANE_W - 1] = 1'b1;
  end

  logic [1:0] warm;
  logic       seen_rst = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) begin
      warm     <= 2'd0;
      seen_rst <= 1'b1;
    end else if (warm != 2'd3) begin
      warm <= warm + 2'd1;
    end
  end

  wire fire = in_valid & in_ready;

  assert_lane_sign_clear_R4: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((res_data & sign_mask) == '0));

  assert_we_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
    res_we |-> res_valid);

  assert_we_follows_guard_R5: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(fire, 2) && $past(in_ready)) |-> (res_we == $past(guard0, 2)));

  assert_two_cycle_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(fire, 2) && $past(in_ready)) |-> res_valid);

  assert_dest_carried_R8: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(fire, 2) && $past(in_ready)) |-> (res_dest == $past(in_dest, 2)));

  assert_min_clips_R2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(fire, 2) && $past(in_ready) && $past(in_operand[LANE_W-1:0], 2) == MIN_NEG)
      |-> (res_data[LANE_W-1:0] == MAX_POS));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !out_ready) |=> (res_valid && $stable(res_data) && $stable(res_we) && $stable(res_dest)));

  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !out_ready) |-> !in_ready);

  assert_reset_empties_R10: assert property (@(posedge clk)
    (seen_rst && $past(rst)) |-> !res_valid);
endmodule

bind dhw_sat_abs_unit dhw_sat_abs_chk #(
  .LANE_W (LANE_W),
  .LANES  (LANES),
  .IDX_W  (IDX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_operand (in_operand),
  .guard0     (in_guard[0]),
  .in_dest    (in_dest),
  .out_ready  (out_ready),
  .res_valid  (res_valid),
  .res_we     (res_we),
  .res_dest   (res_dest),
  .res_data   (res_data)
);

// File: tb/sim_dhw_sat_abs_unit.sv
module sim_dhw_sat_abs_unit;
  localparam int IW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          in_valid = 1'b0, out_ready = 1'b1;
  logic          in_ready, res_valid, res_we;
  logic [31:0]   in_operand = '0, in_guard = '0, res_data;
  logic [IW-1:0] in_dest = '0, res_dest;

  dhw_sat_abs_unit #(.LANE_W(16), .LANES(2), .IDX_W(IW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_guard(in_guard), .in_dest(in_dest),
    .out_ready(out_ready), .res_valid(res_valid), .res_we(res_we),
    .res_dest(res_dest), .res_data(res_data));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0]   q_data [256];
  logic          q_we   [256];
  logic [IW-1:0] q_dest [256];
  int            q_cyc  [256];
  int wp = 0, rp = 0;
  bit lat_chk = 1'b1, prev_hold = 1'b0;
  logic [31:0] p_data; logic p_we; logic [IW-1:0] p_dest;
  logic [15:0] edges [5] = '{16'h0000, 16'h7fff, 16'h8000, 16'h8001, 16'hffff};

  function automatic logic [15:0] ref_lane(logic [15:0] h);
    int v = int'($signed(h));
    if (v < 0) v = -v;
    if (v > 32767) v = 32767;
    return v[15:0];
  endfunction

  function automatic logic [31:0] ref_word(logic [31:0] w);
    return {ref_lane(w[31:16]), ref_lane(w[15:0])};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // One clock: evaluate just before the rising edge, then return after the falling edge.
  task automatic step(output bit fired);
    #1;
    if (prev_hold) begin
      chk(res_valid && res_data == p_data && res_we == p_we && res_dest == p_dest,
          "R9 held result", {res_valid, res_we, 25'(res_dest), 5'd0} ^ res_data, p_data);
    end
    if (res_valid && !out_ready) chk(!in_ready, "R9 in_ready while stalled", 32'(in_ready), 0);
    prev_hold = res_valid && !out_ready;
    p_data = res_data; p_we = res_we; p_dest = res_dest;
    if (res_valid && out_ready) begin
      if (wp == rp) chk(0, "R7 result with nothing issued", res_data, 0);
      else begin
        chk(res_data == q_data[rp % 256], "R1/R2/R3 lane data", res_data, q_data[rp % 256]);
        chk((res_data & 32'h80008000) == 0, "R4 lane sign bits", res_data, res_data & 32'h7fff7fff);
        chk(res_we == q_we[rp % 256], "R5 write enable", 32'(res_we), 32'(q_we[rp % 256]));
        chk(res_dest == q_dest[rp % 256], "R8 destination", 32'(res_dest), 32'(q_dest[rp % 256]));
        if (lat_chk) chk(cyc - q_cyc[rp % 256] == 2, "R6 latency", cyc - q_cyc[rp % 256], 2);
        rp++;
      end
    end
    fired = in_valid && in_ready;
    if (fired) begin
      q_data[wp % 256] = ref_word(in_operand);
      q_we[wp % 256]   = in_guard[0];
      q_dest[wp % 256] = in_dest;
      q_cyc[wp % 256]  = cyc;
      wp++;
    end
    @(posedge clk); cyc++; @(negedge clk);
  endtask

  task automatic send(logic [31:0] op, logic [31:0] g, logic [IW-1:0] d);
    bit f;
    in_valid = 1'b1; in_operand = op; in_guard = g; in_dest = d;
    do step(f); while (!f);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    bit f;
    for (int i = 0; i < n; i++) step(f);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", rp, wp);
    summary();
    $finish;
  end

  initial begin
    bit f;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 chk(!res_valid && in_ready, "R10 reset state", {30'd0, res_valid, in_ready}, 1);
    @(negedge clk);

    // R1 R2 R3 worked vectors, predicate true
    send(32'hffff0032, 1, 1);
    send(32'h80008001, 1, 2);
    send(32'h0032ffff, 1, 3);
    send(32'h7fffffff, 1, 4);
    idle(4);

    // R5: upper predicate bits are ignored, bit 0 decides
    send(32'h12345678, 32'hfffffffe, 5);
    send(32'h80000001, 32'h00000001, 6);
    send(32'hffff8000, 32'hdeadbeef, 7);
    send(32'h00017fff, 32'h00000002, 8);
    idle(4);

    // R1 R2 R3 R7: full sweep of each lane, other lane on boundaries, back to back
    in_valid = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      in_operand = {edges[i % 5], 16'(i)};
      in_guard = 32'(i * 7); in_dest = IW'(i);
      step(f);
    end
    for (int i = 0; i < 65536; i++) begin
      in_operand = {16'(i), edges[(i / 3) % 5]};
      in_guard = 32'(i >> 1); in_dest = IW'(i * 3);
      step(f);
    end
    in_valid = 1'b0;
    idle(4);

    // R9: random offers against random consumer stalls
    lat_chk = 1'b0;
    f = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if (!in_valid || f) begin
        in_valid = $urandom_range(0, 3) != 0;
        in_operand = $urandom(); in_guard = $urandom(); in_dest = IW'($urandom());
        if (i % 17 == 0) in_operand = {edges[i % 5], edges[(i / 5) % 5]};
      end
      out_ready = $urandom_range(0, 2) != 0;
      step(f);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    idle(4);
    lat_chk = 1'b1;

    // R10: reset with both stages full and the consumer stalled
    send(32'h00050005, 1, 9);
    out_ready = 1'b0;
    send(32'h00060006, 1, 10);
    rst = 1'b1;
    step(f);
    rst = 1'b0; prev_hold = 1'b0; out_ready = 1'b1;
    #1 chk(!res_valid, "R10 flush after reset", 32'(res_valid), 0);
    rp = wp;
    @(negedge clk);
    idle(4);
    send(32'h0000fffe, 0, 11);
    idle(4);
    chk(rp == wp, "R10 R7 all results drained", rp, wp);

    summary();
    $finish;
  end
endmodule